// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block produces the system reset for a digital domain. It takes two inputs. The first is a supply-good flag: the digitized output of an undervoltage comparator. The second is an active-low manual reset request, for example from a push button or external logic. Reset is held asserted while the supply is below its threshold. Once the supply recovers, reset stays asserted for a programmable hold time and is then released. If the supply drops again before the hold time ends, the hold restarts from zero.

The manual request only takes effect after it has been held low for a minimum number of consecutive clocks, so short glitches do nothing. A qualified manual request asserts reset at once. When the button is let go, reset stays asserted for the same hold time. Both external inputs pass through two-flop synchronizers. An asynchronous power-on input forces reset and clears every counter, so reset is asserted from the moment power is applied. Two outputs are driven: an active-low reset and its active-high complement. Hold time and qualification time are parameters given in clock cycles.

Top module: `por_seq`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is 0 and `rst_o` is 1 without waiting for a clock. After `por_n` rises at a falling clock edge, with `supply_ok`=1 and `mr_n`=1, `rst_n_o` goes to 1 on the HOLD_CYCLES+2-th rising edge.
- R2: `rst_n_o` is 0 by the second rising edge after `supply_ok` falls (synchronizer latency). It is still 1 after the first of those edges, and it stays 0 for as long as `supply_ok` stays 0.
- R3: When `supply_ok` rises while `mr_n`=1, `rst_n_o` goes to 1 on exactly the HOLD_CYCLES+2-th rising edge after the change.
- R4: If `supply_ok` falls while a hold period is running, the hold count restarts from zero. Release then comes HOLD_CYCLES+2 rising edges after the supply rises again.
- R5: A low on `mr_n` that lasts fewer than MR_MIN_CYCLES consecutive clocks is ignored, and `rst_n_o` stays 1 throughout.
- R6: A low on `mr_n` that lasts at least MR_MIN_CYCLES clocks drives `rst_n_o` to 0 on the MR_MIN_CYCLES+2-th rising edge after the fall.
- R7: After a qualified manual low of L clocks, `rst_n_o` goes back to 1 on rising edge L+HOLD_CYCLES+3, counted from the fall. The hold count stays cleared for as long as `mr_n` is held low, however long that is.
- R8: `rst_o` always equals the inverse of `rst_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Supply-good flag from the undervoltage comparator, asynchronous |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| rst_n_o | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |

## Verification
The assertions assume `por_n` is held low from time zero until the clock is running. They also assume `supply_ok` and `mr_n` change no faster than once per clock, so every level reaches the synchronizer outputs. The bench meets both conditions: it holds `por_n` low over the first edges and changes every input at a falling clock edge. As a result, each change is captured cleanly by the next rising edge, and the edge counts in R2 to R7 hold exactly.

// File: rtl/por_seq.sv
`timescale 1ns/1ps
module por_seq #(
  parameter int HOLD_CYCLES   = 50_000_000,
  parameter int MR_MIN_CYCLES = 38
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic mr_n,
  output logic rst_n_o,
  output logic rst_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int MW = $clog2(MR_MIN_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);
  localparam logic [MW-1:0] MR_LIMIT  = MW'(MR_MIN_CYCLES);

  logic [1:0]    sup_sy, mr_sy;
  logic [MW-1:0] mr_cnt;
  logic [HW-1:0] hold_cnt;
  logic          rst_q;

  wire sup_s  = sup_sy[1];
  wire mr_s   = mr_sy[1];
  wire mr_req = (mr_cnt == MR_LIMIT);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sup_sy <= 2'b00;
      mr_sy  <= 2'b11;
    end else begin
      sup_sy <= {sup_sy[0], supply_ok};
      mr_sy  <= {mr_sy[0], mr_n};
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                mr_cnt <= '0;
    else if (mr_s)             mr_cnt <= '0;
    else if (mr_cnt != MR_LIMIT) mr_cnt <= mr_cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rst_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (!sup_s || mr_req) begin
      rst_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (!rst_q) begin
      if (!mr_s)                      hold_cnt <= '0;
      else if (hold_cnt == HOLD_LAST) begin
        rst_q    <= 1'b1;
        hold_cnt <= '0;
      end else                        hold_cnt <= hold_cnt + 1'b1;
    end

  assign rst_n_o = rst_q & sup_s & ~mr_req;
  assign rst_o   = ~rst_n_o;

  a_r1_por_forces_reset: assert property (@(posedge clk) !por_n |-> !rst_n_o);

  a_r2_supply_low_resets: assert property (@(posedge clk) disable iff (!por_n)
    !$past(supply_ok, 2) |-> !rst_n_o);

  a_r3_release_needs_good: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n_o) |-> ($past(sup_s) && $past(mr_s)));

  a_r4_brownout_restarts: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sup_s) |=> (hold_cnt == '0 && !rst_n_o));

  a_r5_qualify_needs_low: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mr_req) |-> $past(!mr_s));

  a_r7_manual_low_clears: assert property (@(posedge clk) disable iff (!por_n)
    (!mr_s && !rst_q) |=> (hold_cnt == '0));

  a_r3_hold_bound: assert property (@(posedge clk) disable iff (!por_n)
    hold_cnt < HW'(HOLD_CYCLES));
endmodule

// File: tb/sim_por_seq.sv
`timescale 1ns/1ps
module sim_por_seq;
  localparam int HOLD = 20;
  localparam int MIN  = 4;
  localparam int NV   = 6;
  localparam int VLEN [NV] = '{1, 3, 4, 5, 45, 2};
  localparam bit VQUAL[NV] = '{0, 0, 1, 1, 1, 0};

  logic clk = 1'b0;
  logic por_n = 1'b0, supply_ok = 1'b0, mr_n = 1'b1;
  logic rst_n_o, rst_o;
  int total = 0, fails = 0, cmp_bad = 0;

  por_seq #(.HOLD_CYCLES(HOLD), .MR_MIN_CYCLES(MIN)) u0 (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .mr_n(mr_n),
    .rst_n_o(rst_n_o), .rst_o(rst_o));

  always #2 clk = ~clk;

  always @(negedge clk) if (rst_o !== ~rst_n_o) cmp_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!rst_n_o && n < 1000);
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk(rst_n_o == 1'b0, "R1 rst_n_o during por", rst_n_o, 0);
    chk(rst_o == 1'b1, "R1 rst_o during por", rst_o, 1);
    @(negedge clk) supply_ok = 1'b1;
    @(negedge clk) por_n = 1'b1;
    measure(n);
    chk(n == HOLD + 2, "R1 release after por", n, HOLD + 2);

    // R2: supply drop
    repeat (3) @(posedge clk);
    @(negedge clk) supply_ok = 1'b0;
    @(posedge clk); #1;
    chk(rst_n_o == 1'b1, "R2 first edge", rst_n_o, 1);
    @(posedge clk); #1;
    chk(rst_n_o == 1'b0, "R2 second edge", rst_n_o, 0);
    repeat (30) @(posedge clk);
    #1;
    chk(rst_n_o == 1'b0, "R2 held while low", rst_n_o, 0);

    // R3: recovery
    @(negedge clk) supply_ok = 1'b1;
    measure(n);
    chk(n == HOLD + 2, "R3 hold time", n, HOLD + 2);

    // R4: brownout mid-hold
    @(negedge clk) supply_ok = 1'b0;
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk(rst_n_o == 1'b0, "R4 still in hold", rst_n_o, 0);
    @(negedge clk) supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    measure(n);
    chk(n == HOLD + 2, "R4 restarted hold", n, HOLD + 2);

    // R5/R6/R7: manual reset vectors
    for (int v = 0; v < NV; v++) begin
      int first_low, rise;
      first_low = 0;
      rise = 0;
      repeat (4) @(posedge clk);
      @(negedge clk) mr_n = 1'b0;
      for (int k = 1; k <= VLEN[v] + HOLD + 12; k++) begin
        @(posedge clk); #1;
        if (!rst_n_o && first_low == 0) first_low = k;
        if (rst_n_o && first_low != 0 && rise == 0) rise = k;
        if (k == VLEN[v]) begin
          @(negedge clk) mr_n = 1'b1;
        end
      end
      if (VQUAL[v]) begin
        chk(first_low == MIN + 2, "R6 manual assert edge", first_low, MIN + 2);
        chk(rise == VLEN[v] + HOLD + 3, "R7 manual release edge", rise, VLEN[v] + HOLD + 3);
      end else begin
        chk(first_low == 0, "R5 glitch ignored", first_low, 0);
      end
    end

    // R1: asynchronous clear mid-operation
    repeat (3) @(posedge clk);
    #1;
    chk(rst_n_o == 1'b1, "R1 running before clear", rst_n_o, 1);
    por_n = 1'b0;
    #0.5;
    chk(rst_n_o == 1'b0, "R1 async clear rst_n_o", rst_n_o, 0);
    chk(rst_o == 1'b1, "R1 async clear rst_o", rst_o, 1);
    @(negedge clk) por_n = 1'b1;
    measure(n);
    chk(n == HOLD + 2, "R1 release after async clear", n, HOLD + 2);

    chk(cmp_bad == 0, "R8 complement mismatches", cmp_bad, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule